// File: doc/BRIEF.md
# Down-Spread Spectrum Modulation Generator

This block produces a slowly varying offset word that a downstream fractional divider adds to its nominal divide ratio. Since the offset is never negative, the synthesized clock only ever runs at or below its nominal frequency. Sweeping the offset up and down spreads the clock's energy over a band, which lowers its peak emission. The offset follows a symmetric triangle. It starts at zero, climbs to a peak set by the configured depth, and falls back to zero over one modulation period. The period counts reference ticks, so a tick strobe derived from a reference clock sets the absolute modulation rate. A 31.5 kHz rate is a typical target.

The depth is a code in steps of one part per thousand of the nominal divisor. Codes 1 to 25 give 0.1 % up to 2.5 %. The half-period is a power of two in ticks, given as an exponent. A global active-high enable pin gates the spread off. Holding the pin low forces the offset to zero. An alternate-PLL select also forces zero, because only outputs of the first PLL may be spread.

Top module: `ssm_downspread`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `spread_offset` is 0.
- R2: The triangle's apex equals floor(`nominal_div` × `depth_code` / 1000). It is reached when the phase equals H, where H = 2^k.
- R3: For phase p in 0..2H-1, the offset equals floor(peak × pos / H), with pos = p for p < H and pos = 2H − p otherwise. The offset is unsigned and never exceeds the apex.
- R4: The phase advances by one only on a cycle with `ref_tick` high. After value 2H−1 it wraps to 0, so one modulation period is 2H ticks. Without a tick the phase holds.
- R5: The effective exponent k is `half_exp` clamped to the range 1..MAX_K (default 10). A value of 0 acts as 1, and values above MAX_K act as MAX_K.
- R6: With `spread_on` low, the offset is 0 from the next sample. The phase also returns to 0, so after re-enabling, the first tick gives phase 1.
- R7: With `use_alt_pll` high, the offset is 0 from the next sample, whatever the depth and enable inputs are.
- R8: Depth codes 0 and 26..31 (5-bit field) give a zero offset and hold the phase at 0.
- R9: The offset is registered and follows the phase it produces. After a clock edge that advances the phase to p, `spread_offset` already shows the value for p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe that advances the modulation phase |
| spread_on | input | 1 | Global spread enable; low forces zero offset |
| use_alt_pll | input | 1 | High when the output is fed by the second PLL; forces zero offset |
| depth_code | input | 5 | Depth in 0.1 % steps, legal 1..25 |
| half_exp | input | KW (4) | Half-period exponent, H = 2^half_exp ticks, clamped to 1..MAX_K |
| nominal_div | input | DIV_W (16) | Nominal divide ratio the offset scales from |
| spread_offset | output | DIV_W (16) | Unsigned offset to add to the divide ratio |

## Verification
A stuck or mis-wrapping phase counter shows up at the port within one modulation period. Either the offset fails to reach its apex at tick H, or it fails to return to zero at tick 2H. Both are visible after at most 2H ticks. A wrong apex product or scaling shift misplaces every ramp sample at the first nonzero tick. A gate that misses a disable condition leaves a nonzero offset on the very next sample. Because every output sample is a pure function of the tick count since enable, the bench predicts each cycle's value exactly.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned DEPTH_LO = 1;
  localparam int unsigned DEPTH_HI = 25;
  localparam int unsigned PERMILLE = 1000;

  // Which half of the triangle the next phase sits in.
  typedef enum logic {SL_DEEPEN = 1'b0, SL_RECOVER = 1'b1} slope_e;

  function automatic logic code_legal(input logic [CODE_W-1:0] c);
    return (c >= CODE_W'(DEPTH_LO)) && (c <= CODE_W'(DEPTH_HI));
  endfunction
endpackage

// File: rtl/ssm_gate.sv
module ssm_gate
  import ssm_pkg::*;
(
  input  logic              spread_on,
  input  logic              use_alt_pll,
  input  logic [CODE_W-1:0] depth_code,
  output logic              run
);
  // Spread runs only on the first PLL, with the pin high and a legal depth.
  always_comb run = spread_on && !use_alt_pll && code_legal(depth_code);
endmodule

// File: rtl/ssm_phase.sv
module ssm_phase
  import ssm_pkg::*;
#(
  parameter  int unsigned MAX_K = 10,
  parameter  int unsigned KW    = 4,
  localparam int unsigned PH_W  = MAX_K + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic [KW-1:0]   half_exp,
  output logic [KW-1:0]   k_eff,
  output logic [PH_W-1:0] half,
  output logic [PH_W-1:0] phase_nx,
  output slope_e          slope_nx
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] last;
  logic            wrap_evt;

  always_comb begin
    if (half_exp < KW'(1))            k_eff = KW'(1);
    else if (half_exp > KW'(MAX_K))   k_eff = KW'(MAX_K);
    else                              k_eff = half_exp;
  end

  always_comb begin
    half     = PH_W'(1) << k_eff;
    last     = {PH_W{1'b1}} >> (KW'(MAX_K) - k_eff);
    wrap_evt = run && tick && (phase_q >= last);
    if (!run)          phase_nx = '0;
    else if (wrap_evt) phase_nx = '0;
    else if (tick)     phase_nx = phase_q + PH_W'(1);
    else               phase_nx = phase_q;
    slope_nx = (phase_nx >= half) ? SL_RECOVER : SL_DEEPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_nx;
  end

  // R4: no tick, no movement
  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(phase_q));
  // R4: end of period returns to the start
  p_wrap_to_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> phase_q == '0);
  // R9: a tick inside the period steps by exactly one
  p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && !wrap_evt |=> phase_q == $past(phase_q) + PH_W'(1));
  // R6: gated off means the phase restarts
  p_idle_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> phase_q == '0);
endmodule

// File: rtl/ssm_shape.sv
module ssm_shape
  import ssm_pkg::*;
#(
  parameter  int unsigned DIV_W  = 16,
  parameter  int unsigned MAX_K  = 10,
  parameter  int unsigned KW     = 4,
  localparam int unsigned PH_W   = MAX_K + 1,
  localparam int unsigned PROD_W = DIV_W + CODE_W,
  localparam int unsigned MUL_W  = DIV_W + PH_W
) (
  input  logic              run,
  input  logic [DIV_W-1:0]  nominal,
  input  logic [CODE_W-1:0] code,
  input  logic [PH_W-1:0]   phase_nx,
  input  logic [PH_W-1:0]   half,
  input  slope_e            slope_nx,
  input  logic [KW-1:0]     k_eff,
  output logic [DIV_W-1:0]  peak,
  output logic [DIV_W-1:0]  level
);
  logic [PH_W-1:0] pos;

  // Apex of the triangle: nominal * code / 1000, rounded down.
  function automatic logic [DIV_W-1:0] peak_of(input logic [DIV_W-1:0] nom,
                                               input logic [CODE_W-1:0] c);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;
    prod = PROD_W'(nom) * PROD_W'(c);
    quo  = prod / PROD_W'(PERMILLE);
    return quo[DIV_W-1:0];
  endfunction

  // Ramp sample: apex * pos / 2^k, rounded down; pos never exceeds 2^k.
  function automatic logic [DIV_W-1:0] scale_tri(input logic [DIV_W-1:0] pk,
                                                 input logic [PH_W-1:0]  p,
                                                 input logic [KW-1:0]    k);
    logic [MUL_W-1:0] prod;
    prod = MUL_W'(pk) * MUL_W'(p);
    prod = prod >> k;
    return prod[DIV_W-1:0];
  endfunction

  always_comb begin
    peak = peak_of(nominal, code);
    if (slope_nx == SL_RECOVER) pos = half - (phase_nx - half);
    else                        pos = phase_nx;
    level = run ? scale_tri(peak, pos, k_eff) : '0;
  end
endmodule

// File: rtl/ssm_downspread.sv
module ssm_downspread
  import ssm_pkg::*;
#(
  parameter  int unsigned DIV_W = 16,
  parameter  int unsigned MAX_K = 10,
  parameter  int unsigned KW    = 4,
  localparam int unsigned PH_W  = MAX_K + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              spread_on,
  input  logic              use_alt_pll,
  input  logic [CODE_W-1:0] depth_code,
  input  logic [KW-1:0]     half_exp,
  input  logic [DIV_W-1:0]  nominal_div,
  output logic [DIV_W-1:0]  spread_offset
);
  logic             run_w;
  logic [KW-1:0]    k_eff_w;
  logic [PH_W-1:0]  half_w;
  logic [PH_W-1:0]  phase_nx_w;
  slope_e           slope_nx_w;
  logic [DIV_W-1:0] peak_w;
  logic [DIV_W-1:0] level_w;

  ssm_gate u_gate (
    .spread_on   (spread_on),
    .use_alt_pll (use_alt_pll),
    .depth_code  (depth_code),
    .run         (run_w)
  );

  ssm_phase #(.MAX_K(MAX_K), .KW(KW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .tick     (ref_tick),
    .half_exp (half_exp),
    .k_eff    (k_eff_w),
    .half     (half_w),
    .phase_nx (phase_nx_w),
    .slope_nx (slope_nx_w)
  );

  ssm_shape #(.DIV_W(DIV_W), .MAX_K(MAX_K), .KW(KW)) u_shape (
    .run      (run_w),
    .nominal  (nominal_div),
    .code     (depth_code),
    .phase_nx (phase_nx_w),
    .half     (half_w),
    .slope_nx (slope_nx_w),
    .k_eff    (k_eff_w),
    .peak     (peak_w),
    .level    (level_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spread_offset <= '0;
    else        spread_offset <= level_w;
  end

  // R3: down spread only, bounded by the apex
  p_below_apex_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_w |=> spread_offset <= $past(peak_w));
  // R3: phase zero is the nominal point
  p_start_nominal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_w && (phase_nx_w == '0) |=> spread_offset == '0);
  // R6: enable pin low zeroes the offset
  p_pin_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !spread_on |=> spread_offset == '0);
  // R7: second-PLL outputs are never spread
  p_alt_pll_r7: assert property (@(posedge clk) disable iff (!rst_n)
    use_alt_pll |=> spread_offset == '0);
  // R8: out-of-range depth code gives no spread
  p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !code_legal(depth_code) |=> spread_offset == '0);
endmodule

// File: tb/ssm_downspread_tb.sv
module ssm_downspread_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        spread_on = 1'b0;
  logic        use_alt_pll = 1'b0;
  logic [4:0]  depth_code = 5'd0;
  logic [3:0]  half_exp = 4'd1;
  logic [15:0] nominal_div = 16'd0;
  logic [15:0] spread_offset;

  int n_checks = 0;
  int n_errs   = 0;
  int m_ph     = 0;

  // nominal(16) | code(5) | exponent(4)
  localparam logic [24:0] VEC [0:5] = '{
    {16'd1000,  5'd25, 4'd3},
    {16'd4000,  5'd1,  4'd2},
    {16'd65535, 5'd25, 4'd5},
    {16'd1234,  5'd13, 4'd4},
    {16'd50000, 5'd7,  4'd1},
    {16'd777,   5'd10, 4'd6}
  };

  always #2 clk = ~clk;

  ssm_downspread u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .spread_on(spread_on),
    .use_alt_pll(use_alt_pll), .depth_code(depth_code), .half_exp(half_exp),
    .nominal_div(nominal_div), .spread_offset(spread_offset)
  );

  function automatic int kc(input int k);
    if (k < 1) return 1;
    if (k > 10) return 10;
    return k;
  endfunction

  function automatic int apex(input int nom, input int code);
    return (nom * code) / 1000;
  endfunction

  function automatic int model_active();
    return (spread_on && !use_alt_pll && depth_code >= 1 && depth_code <= 25) ? 1 : 0;
  endfunction

  function automatic int expect_off();
    int h, p;
    if (model_active() == 0) return 0;
    h = 2 ** kc(int'(half_exp));
    p = (m_ph <= h) ? m_ph : (2 * h - m_ph);
    return (apex(int'(nominal_div), int'(depth_code)) * p) / h;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errs++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one clock: drive tick, advance the model at the edge, check at the next falling edge
  task automatic step(input logic t, input string tag);
    int per;
    ref_tick = t;
    @(posedge clk);
    per = 2 * (2 ** kc(int'(half_exp)));
    if (model_active() == 0) m_ph = 0;
    else if (t) m_ph = (m_ph >= per - 1) ? 0 : m_ph + 1;
    @(negedge clk);
    check(tag, int'(spread_offset), expect_off());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    // R1: reset state
    spread_on = 1'b1; depth_code = 5'd20; nominal_div = 16'd5000; half_exp = 4'd2;
    ref_tick = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 during reset", int'(spread_offset), 0);
    rst_n = 1'b1;
    m_ph = 0;
    ref_tick = 1'b0;
    spread_on = 1'b0;
    step(1'b0, "R1 first sample");
    spread_on = 1'b1;

    // Table walk: two full periods per entry, one tick per cycle
    foreach (VEC[i]) begin
      int h;
      nominal_div = VEC[i][24:9];
      depth_code  = VEC[i][8:4];
      half_exp    = VEC[i][3:0];
      spread_on   = 1'b0;
      step(1'b1, "R6 clear between entries");
      spread_on   = 1'b1;
      h = 2 ** kc(int'(half_exp));
      for (int s = 0; s < 4 * h; s++) begin
        step(1'b1, "R3 ramp sample");
        if (m_ph == h) check("R2 apex", int'(spread_offset), apex(int'(nominal_div), int'(depth_code)));
        if (m_ph == 0) check("R4 period end", int'(spread_offset), 0);
      end
    end

    // R9 / R4: sparse ticks, output holds between ticks
    nominal_div = 16'd8000; depth_code = 5'd25; half_exp = 4'd3;
    for (int s = 0; s < 40; s++) step((s % 3) == 0, "R9 sparse tick");

    // R6: drop enable mid-ramp, then restart from phase 0
    for (int s = 0; s < 5; s++) step(1'b1, "R6 pre-disable");
    spread_on = 1'b0;
    step(1'b1, "R6 offset cleared");
    step(1'b1, "R6 stays cleared");
    spread_on = 1'b1;
    step(1'b1, "R6 restart phase one");
    check("R6 restart value", int'(spread_offset), (200 * 1) / 8);

    // R7: alternate PLL ignores spread settings
    use_alt_pll = 1'b1;
    for (int s = 0; s < 6; s++) step(1'b1, "R7 alt pll zero");
    use_alt_pll = 1'b0;
    for (int s = 0; s < 6; s++) step(1'b1, "R7 back on first pll");

    // R8: illegal depth codes
    depth_code = 5'd0;
    for (int s = 0; s < 4; s++) step(1'b1, "R8 code 0");
    depth_code = 5'd26;
    for (int s = 0; s < 4; s++) step(1'b1, "R8 code 26");
    depth_code = 5'd31;
    for (int s = 0; s < 4; s++) step(1'b1, "R8 code 31");
    depth_code = 5'd1;
    step(1'b1, "R8 legal low code");

    // R5: exponent clamping at both ends
    nominal_div = 16'd60000; depth_code = 5'd25;
    spread_on = 1'b0; half_exp = 4'd0;
    step(1'b1, "R5 clear");
    spread_on = 1'b1;
    for (int s = 0; s < 8; s++) step(1'b1, "R5 exponent 0 acts as 1");
    spread_on = 1'b0; half_exp = 4'd15;
    step(1'b1, "R5 clear");
    spread_on = 1'b1;
    for (int s = 0; s < 2100; s++) begin
      step(1'b1, "R5 exponent 15 acts as 10");
      if (m_ph == 1024) check("R5 apex at 1024", int'(spread_offset), 1500);
    end

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule